// File: doc/BRIEF.md
# Dual-Bank Write Arbiter

This block sits in front of a 128-Mbit flash array of 16-bit words and decides, one request at a time, whether a new operation may begin. The array is split into sixteen banks of 512K words. Fifteen of them are uniform, made of eight 64K-word main blocks. One holds four small 16K-word blocks plus seven main blocks. An input pin chooses whether that mixed bank is the highest or the lowest bank. That gives 131 erase blocks, each with its own index.

Only one bank may be writing (programming or erasing) at a time. Reads to other banks go ahead meanwhile. An erase may be paused so that another block can be programmed, and a program may be paused so that other blocks can be read. Every request receives exactly one grant or reject pulse in the cycle after it is taken. That pulse also carries the request's bank and block index. The arbiter also reports which bank is writing and what kind of operation is paused. A completion pulse from the program/erase controller ends the running operation.

Top module: `dual_bank_arbiter`

## Requirements
- R1: With `param_top`=0 the mixed bank is bank 0. Word addresses below 0x010000 map to small blocks 0..3 (address bits 15:14). The rest of bank 0 maps to blocks 4..10. An address in bank n (n from 1 to 15) maps to block 11+8*(n-1)+bits 18:16. The bank is address bits 22:19.
- R2: With `param_top`=1 the mixed bank is bank 15. Addresses from 0x7F0000 up map to small blocks 127..130 (bits 15:14). Every other address maps to block 8*bank + bits 18:16, so blocks 0..126.
- R3: A request is taken when `req_valid` and `req_ready` are both high. In the next cycle `rsp_valid` is high with exactly one of `rsp_grant` and `rsp_reject` set. In any cycle after no request was taken, all three are low. After reset every output is low.
- R4: Opcodes: 0 read, 1 program, 2 erase, 3 suspend, 4 resume. Program and erase are granted only when no operation is running or paused. The one exception is R7. A granted program or erase sets `wr_busy` and puts its bank on `busy_bank`.
- R5: While a program or erase is running and not paused, a read to another bank is granted with `rsp_status` low. A read to the busy bank is granted with `rsp_status` high, which marks a status read.
- R6: Suspend is granted only while a program or erase is running and not paused. `susp_kind` is 2'b01 for a paused program and 2'b10 for a paused erase. Resume returns to the running state with `susp_kind` 2'b00.
- R7: While an erase is paused, a program to any block other than the paused one is granted and runs nested. During the nested program, `busy_bank` shows its bank. A read to that bank is a status read.
- R8: While a program is paused, a read to any other block is granted as an array read, even in the same bank. A read to the paused block is rejected.
- R9: Resume is rejected when nothing is paused and when a nested program is still running.
- R10: `req_ready` is low in any cycle where `pe_done` is high. `pe_done` ends a running program or erase, or ends a nested program and returns to the paused erase. It has no effect when nothing is running.
- R11: Opcodes 5, 6 and 7 are rejected and change no state.
- R12: While an erase is paused, a read or a program that targets the paused block is rejected. Another block in the same bank is readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| param_top | input | 1 | 1: mixed bank at top; 0: at bottom |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 3 | Request opcode |
| req_addr | input | 23 | Word address of the request |
| pe_done | input | 1 | Running program/erase finished |
| rsp_valid | output | 1 | Response for last taken request |
| rsp_grant | output | 1 | Request granted |
| rsp_reject | output | 1 | Request rejected |
| rsp_status | output | 1 | Granted read is a status read |
| rsp_bank | output | 4 | Bank of the answered request |
| rsp_block | output | 8 | Block index of the answered request |
| wr_busy | output | 1 | A program or erase is running |
| busy_bank | output | 4 | Bank of the running write, else 0 |
| susp_kind | output | 2 | Paused operation kind |

## Verification
The map is tried with addresses at the edges of the small blocks, the first main block of the mixed bank, bank boundaries and the last word, under both `param_top` settings. This separates an off-by-one in the small-block region from a wrong bank offset. The permission logic is driven through full erase-suspend-program-resume and program-suspend-resume sequences with reads aimed at the busy bank, the paused block, a sibling block in the same bank and a foreign bank. This tells status reads, array reads and rejects apart. Completion pulses arrive together with a pending request and while idle, and undefined opcodes are mixed in, which shows that neither one disturbs state.

// File: rtl/dba_pkg.sv
// Shared types for the dual-bank write arbiter.
// Assumes a 3-bit opcode field; codes above 4 are undefined.
package dba_pkg;
    typedef enum logic [2:0] {
        OP_READ   = 3'd0,
        OP_PROG   = 3'd1,
        OP_ERASE  = 3'd2,
        OP_SUSP   = 3'd3,
        OP_RESUME = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_ERASE,
        ST_PSUSP,
        ST_ESUSP,
        ST_ESUSP_PROG
    } arb_st_e;
endpackage

// File: rtl/dba_block_map.sv
// Maps a word address to a bank and a global block index.
// Assumes main blocks per bank and small blocks per main slot are powers of two,
// and that the mixed bank replaces one main slot with the small blocks.
module dba_block_map #(
    parameter int ADDR_W     = 23,
    parameter int BANK_BITS  = 4,
    parameter int MAIN_BITS  = 3,
    parameter int PARAM_BITS = 2,
    parameter int BLK_W      = 8
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 param_top,
    output logic [BANK_BITS-1:0] bank,
    output logic [BLK_W-1:0]     blk
);
    localparam int NBANK      = 1 << BANK_BITS;
    localparam int NMAIN      = 1 << MAIN_BITS;
    localparam int NPARAM     = 1 << PARAM_BITS;
    localparam int MAIN_LSB   = ADDR_W - BANK_BITS - MAIN_BITS;
    localparam int PARAM_LSB  = MAIN_LSB - PARAM_BITS;
    localparam int BOT_MAIN0  = NPARAM + NMAIN - 1;
    localparam int TOP_PARAM0 = NBANK * NMAIN - 1;

    logic [MAIN_BITS-1:0]  mb;
    logic [PARAM_BITS-1:0] pb;
    logic [BANK_BITS-1:0]  bank_m1;

    assign bank    = addr[ADDR_W-1 -: BANK_BITS];
    assign mb      = addr[MAIN_LSB +: MAIN_BITS];
    assign pb      = addr[PARAM_LSB +: PARAM_BITS];
    assign bank_m1 = bank - BANK_BITS'(1);

    // Block index for the selected placement of the mixed bank.
    always_comb begin
        if (param_top) begin
            if (bank == '1 && mb == '1)
                blk = BLK_W'(TOP_PARAM0) + BLK_W'(pb);
            else
                blk = BLK_W'({bank, mb});
        end else begin
            if (bank == '0)
                blk = (mb == '0) ? BLK_W'(pb) : BLK_W'(mb) + BLK_W'(NPARAM - 1);
            else
                blk = BLK_W'(BOT_MAIN0) + BLK_W'({bank_m1, mb});
        end
    end
endmodule

// File: rtl/dba_policy.sv
// Pure decision logic: grants or rejects one request for the current state.
// Assumes the caller never presents a request in a completion cycle.
module dba_policy
    import dba_pkg::*;
#(
    parameter int BANK_BITS = 4,
    parameter int BLK_W     = 8
) (
    input  arb_st_e              st,
    input  logic [2:0]           op,
    input  logic [BANK_BITS-1:0] req_bank,
    input  logic [BLK_W-1:0]     req_blk,
    input  logic [BANK_BITS-1:0] pri_bank,
    input  logic [BLK_W-1:0]     pri_blk,
    input  logic [BANK_BITS-1:0] nst_bank,
    output logic                 grant,
    output logic                 status,
    output arb_st_e              st_nxt
);
    logic hit_blk;
    assign hit_blk = (req_blk == pri_blk);

    // Permission table by state and opcode.
    always_comb begin
        grant  = 1'b0;
        status = 1'b0;
        st_nxt = st;
        case (st)
            ST_IDLE: begin
                if (op == OP_READ) begin
                    grant = 1'b1;
                end else if (op == OP_PROG) begin
                    grant = 1'b1; st_nxt = ST_PROG;
                end else if (op == OP_ERASE) begin
                    grant = 1'b1; st_nxt = ST_ERASE;
                end
            end
            ST_PROG, ST_ERASE: begin
                if (op == OP_READ) begin
                    grant  = 1'b1;
                    status = (req_bank == pri_bank);
                end else if (op == OP_SUSP) begin
                    grant  = 1'b1;
                    st_nxt = (st == ST_PROG) ? ST_PSUSP : ST_ESUSP;
                end
            end
            ST_PSUSP: begin
                if (op == OP_READ) begin
                    grant = !hit_blk;
                end else if (op == OP_RESUME) begin
                    grant = 1'b1; st_nxt = ST_PROG;
                end
            end
            ST_ESUSP: begin
                if (op == OP_READ) begin
                    grant = !hit_blk;
                end else if (op == OP_PROG && !hit_blk) begin
                    grant = 1'b1; st_nxt = ST_ESUSP_PROG;
                end else if (op == OP_RESUME) begin
                    grant = 1'b1; st_nxt = ST_ERASE;
                end
            end
            ST_ESUSP_PROG: begin
                if (op == OP_READ) begin
                    if (req_bank == nst_bank) begin
                        grant = 1'b1; status = 1'b1;
                    end else begin
                        grant = !hit_blk;
                    end
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dual_bank_arbiter.sv
// Top: single-writer-bank arbiter with erase/program suspend nesting.
// Assumes pe_done pulses only refer to the operation currently running;
// requests are held off (req_ready low) in a completion cycle.
module dual_bank_arbiter
    import dba_pkg::*;
#(
    parameter int ADDR_W     = 23,
    parameter int BANK_BITS  = 4,
    parameter int MAIN_BITS  = 3,
    parameter int PARAM_BITS = 2,
    localparam int NBLK      = ((1 << BANK_BITS) - 1) * (1 << MAIN_BITS)
                               + (1 << MAIN_BITS) - 1 + (1 << PARAM_BITS),
    localparam int BLK_W     = $clog2(NBLK)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 param_top,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [2:0]           req_op,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 pe_done,
    output logic                 rsp_valid,
    output logic                 rsp_grant,
    output logic                 rsp_reject,
    output logic                 rsp_status,
    output logic [BANK_BITS-1:0] rsp_bank,
    output logic [BLK_W-1:0]     rsp_block,
    output logic                 wr_busy,
    output logic [BANK_BITS-1:0] busy_bank,
    output logic [1:0]           susp_kind
);
    arb_st_e              st, st_nxt;
    logic [BANK_BITS-1:0] pri_bank, nst_bank, map_bank;
    logic [BLK_W-1:0]     pri_blk, map_blk;
    logic                 accept, grant, status;

    assign req_ready = !pe_done;
    assign accept    = req_valid && req_ready;

    dba_block_map #(
        .ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS), .MAIN_BITS(MAIN_BITS),
        .PARAM_BITS(PARAM_BITS), .BLK_W(BLK_W)
    ) u_map (
        .addr(req_addr), .param_top(param_top), .bank(map_bank), .blk(map_blk)
    );

    dba_policy #(.BANK_BITS(BANK_BITS), .BLK_W(BLK_W)) u_pol (
        .st(st), .op(req_op), .req_bank(map_bank), .req_blk(map_blk),
        .pri_bank(pri_bank), .pri_blk(pri_blk), .nst_bank(nst_bank),
        .grant(grant), .status(status), .st_nxt(st_nxt)
    );

    // Operation state: completions first, then granted requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            pri_bank <= '0;
            pri_blk  <= '0;
            nst_bank <= '0;
        end else if (pe_done) begin
            if (st == ST_PROG || st == ST_ERASE) st <= ST_IDLE;
            else if (st == ST_ESUSP_PROG)        st <= ST_ESUSP;
        end else if (accept && grant) begin
            st <= st_nxt;
            if (st == ST_IDLE && st_nxt != ST_IDLE) begin
                pri_bank <= map_bank;
                pri_blk  <= map_blk;
            end
            if (st == ST_ESUSP && st_nxt == ST_ESUSP_PROG) nst_bank <= map_bank;
        end
    end

    // One-cycle response to each taken request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_grant  <= 1'b0;
            rsp_reject <= 1'b0;
            rsp_status <= 1'b0;
            rsp_bank   <= '0;
            rsp_block  <= '0;
        end else begin
            rsp_valid  <= accept;
            rsp_grant  <= accept && grant;
            rsp_reject <= accept && !grant;
            rsp_status <= accept && grant && status;
            if (accept) begin
                rsp_bank  <= map_bank;
                rsp_block <= map_blk;
            end
        end
    end

    // Status outputs decoded from the state.
    always_comb begin
        wr_busy   = (st == ST_PROG) || (st == ST_ERASE) || (st == ST_ESUSP_PROG);
        busy_bank = (st == ST_ESUSP_PROG) ? nst_bank :
                    (st == ST_PROG || st == ST_ERASE) ? pri_bank : '0;
        susp_kind = (st == ST_PSUSP) ? 2'b01 :
                    (st == ST_ESUSP || st == ST_ESUSP_PROG) ? 2'b10 : 2'b00;
    end
endmodule

// File: rtl/dba_checker.sv
// Temporal checks on the arbiter's ports; attached by bind below.
// Assumes the synchronous active-low reset of the top module.
module dba_checker
    import dba_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [2:0] req_op,
    input logic       pe_done,
    input logic       rsp_valid,
    input logic       rsp_grant,
    input logic       rsp_reject,
    input logic       rsp_status,
    input logic       wr_busy,
    input logic [1:0] susp_kind
);
    assert_one_verdict_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_grant ^ rsp_reject));

    assert_no_stray_verdict_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_grant && !rsp_reject));

    assert_rsp_after_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    assert_no_rsp_without_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !rsp_valid);

    assert_status_is_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_status |-> rsp_grant);

    assert_busy_needs_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_busy) |-> (rsp_valid && rsp_grant));

    assert_susp_kind_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(susp_kind));

    assert_resume_needs_pause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op == OP_RESUME && susp_kind == 2'b00) |=> rsp_reject);

    assert_hold_on_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pe_done |-> !req_ready);
endmodule

bind dual_bank_arbiter dba_checker u_dba_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .pe_done(pe_done), .rsp_valid(rsp_valid),
    .rsp_grant(rsp_grant), .rsp_reject(rsp_reject), .rsp_status(rsp_status),
    .wr_busy(wr_busy), .susp_kind(susp_kind)
);

// File: tb/dual_bank_arbiter_bench.sv
module dual_bank_arbiter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        param_top = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_op = 3'd0;
    logic [22:0] req_addr = '0;
    logic        pe_done = 1'b0;
    logic        rsp_valid, rsp_grant, rsp_reject, rsp_status, wr_busy;
    logic [3:0]  rsp_bank, busy_bank;
    logic [7:0]  rsp_block;
    logic [1:0]  susp_kind;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference state: 0 idle, 1 program, 2 erase, 3 program paused,
    // 4 erase paused, 5 erase paused with nested program.
    int m_st = 0, m_pbank = 0, m_pblk = 0, m_nbank = 0;
    bit e_valid, e_grant, e_reject, e_status;
    int e_bank, e_blk;

    always #2 clk = ~clk;

    dual_bank_arbiter u_dual_bank_arbiter (
        .clk(clk), .rst_n(rst_n), .param_top(param_top), .req_valid(req_valid),
        .req_ready(req_ready), .req_op(req_op), .req_addr(req_addr),
        .pe_done(pe_done), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
        .rsp_reject(rsp_reject), .rsp_status(rsp_status), .rsp_bank(rsp_bank),
        .rsp_block(rsp_block), .wr_busy(wr_busy), .busy_bank(busy_bank),
        .susp_kind(susp_kind)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int ref_blk(input int a, input bit top);
        if (!top) return (a < 65536) ? a / 16384 : 3 + a / 65536;
        return (a >= 'h7F0000) ? 127 + (a - 'h7F0000) / 16384 : a / 65536;
    endfunction

    task automatic model(input bit v, input int op, input int a, input bit d);
        int bank, blk, ns;
        bit g, s;
        e_valid = 0; e_grant = 0; e_reject = 0; e_status = 0;
        if (d) begin
            if (m_st == 1 || m_st == 2) m_st = 0;
            else if (m_st == 5) m_st = 4;
        end else if (v) begin
            bank = a / 524288;
            blk  = ref_blk(a, param_top);
            g = 0; s = 0; ns = m_st;
            case (op)
                0: begin
                    if (m_st == 0) g = 1;
                    else if (m_st == 1 || m_st == 2) begin g = 1; s = (bank == m_pbank); end
                    else if (m_st == 5 && bank == m_nbank) begin g = 1; s = 1; end
                    else g = (blk != m_pblk);
                end
                1: if (m_st == 0) begin g = 1; ns = 1; end
                   else if (m_st == 4 && blk != m_pblk) begin g = 1; ns = 5; end
                2: if (m_st == 0) begin g = 1; ns = 2; end
                3: if (m_st == 1) begin g = 1; ns = 3; end
                   else if (m_st == 2) begin g = 1; ns = 4; end
                4: if (m_st == 3) begin g = 1; ns = 1; end
                   else if (m_st == 4) begin g = 1; ns = 2; end
                default: g = 0;
            endcase
            if (g && m_st == 0 && ns != 0) begin m_pbank = bank; m_pblk = blk; end
            if (g && m_st == 4 && ns == 5) m_nbank = bank;
            if (g) m_st = ns;
            e_valid = 1; e_grant = g; e_reject = !g; e_status = g && s;
            e_bank = bank; e_blk = blk;
        end
    endtask

    task automatic compare(input string tag);
        int eb, ek;
        eb = (m_st == 5) ? m_nbank : (m_st == 1 || m_st == 2) ? m_pbank : 0;
        ek = (m_st == 3) ? 1 : (m_st == 4 || m_st == 5) ? 2 : 0;
        chk(tag, "rsp_valid", rsp_valid, e_valid);
        chk(tag, "rsp_grant", rsp_grant, e_grant);
        chk(tag, "rsp_reject", rsp_reject, e_reject);
        chk(tag, "rsp_status", rsp_status, e_status);
        if (e_valid) begin
            chk(tag, "rsp_bank", rsp_bank, e_bank);
            chk(tag, "rsp_block", rsp_block, e_blk);
        end
        chk(tag, "wr_busy", wr_busy, (m_st == 1 || m_st == 2 || m_st == 5) ? 1 : 0);
        chk(tag, "busy_bank", busy_bank, eb);
        chk(tag, "susp_kind", susp_kind, ek);
    endtask

    // One clock: drive at falling edge, model at rising edge, compare 1 ns later.
    task automatic step(input bit v, input int op, input int a, input bit d, input string tag);
        @(negedge clk);
        req_valid = v; req_op = op[2:0]; req_addr = a[22:0]; pe_done = d;
        #1;
        chk(d ? "R10" : tag, "req_ready", req_ready, d ? 0 : 1);
        @(posedge clk);
        model(v, op, a, d);
        #1;
        compare(tag);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #400000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        compare("R3");   // reset state, all outputs low

        // R1: bottom placement of the mixed bank
        param_top = 1'b0;
        step(1, 0, 'h000000, 0, "R1");
        step(1, 0, 'h004000, 0, "R1");
        step(1, 0, 'h00C000, 0, "R1");
        step(1, 0, 'h010000, 0, "R1");
        step(1, 0, 'h070000, 0, "R1");
        step(1, 0, 'h080000, 0, "R1");
        step(1, 0, 'h7F0000, 0, "R1");
        step(1, 0, 'h7FC000, 0, "R1");
        step(0, 0, 0, 0, "R3");

        // R2: top placement of the mixed bank
        @(negedge clk); param_top = 1'b1;
        step(1, 0, 'h000000, 0, "R2");
        step(1, 0, 'h770000, 0, "R2");
        step(1, 0, 'h780000, 0, "R2");
        step(1, 0, 'h7F0000, 0, "R2");
        step(1, 0, 'h7F4000, 0, "R2");
        step(1, 0, 'h7FC000, 0, "R2");

        // Erase path with suspend and nested program
        step(1, 2, 'h100000, 0, "R4");   // erase bank 2 granted
        step(1, 1, 'h280000, 0, "R4");   // program bank 5 rejected
        step(1, 2, 'h100000, 0, "R4");   // second erase rejected
        step(1, 0, 'h280000, 0, "R5");   // foreign bank array read
        step(1, 0, 'h110000, 0, "R5");   // busy bank status read
        step(1, 4, 'h000000, 0, "R9");   // resume with nothing paused
        step(1, 3, 'h000000, 0, "R6");   // suspend erase
        step(1, 0, 'h100000, 0, "R12");  // read paused block rejected
        step(1, 0, 'h110000, 0, "R12");  // sibling block readable
        step(1, 1, 'h100004, 0, "R12");  // program paused block rejected
        step(1, 2, 'h300000, 0, "R4");   // erase while paused rejected
        step(1, 1, 'h300000, 0, "R7");   // nested program granted
        step(1, 0, 'h300000, 0, "R7");   // status read of nested bank
        step(1, 0, 'h100000, 0, "R12");  // paused block still rejected
        step(1, 4, 'h000000, 0, "R9");   // resume during nested program
        step(1, 3, 'h000000, 0, "R6");   // suspend of nested program rejected
        step(1, 0, 'h000000, 1, "R10");  // nested done, request held off
        step(1, 4, 'h000000, 0, "R6");   // resume erase
        step(0, 0, 0, 1, "R10");         // erase done
        step(0, 0, 0, 1, "R10");         // done while idle ignored
        step(1, 5, 'h100000, 0, "R11");
        step(1, 6, 'h100000, 0, "R11");
        step(1, 7, 'h100000, 0, "R11");
        step(1, 4, 'h000000, 0, "R9");

        // Program path with suspend (bottom placement)
        @(negedge clk); param_top = 1'b0;
        step(1, 1, 'h200000, 0, "R4");
        step(1, 3, 'h000000, 0, "R6");
        step(1, 0, 'h200000, 0, "R8");   // paused block rejected
        step(1, 0, 'h210000, 0, "R8");   // same bank other block
        step(1, 0, 'h000000, 0, "R8");
        step(1, 1, 'h500000, 0, "R4");   // program during program pause
        step(1, 2, 'h500000, 0, "R4");
        step(1, 5, 'h500000, 0, "R11");
        step(1, 4, 'h000000, 0, "R6");
        step(1, 0, 'h200000, 0, "R5");
        step(0, 0, 0, 1, "R10");
        step(1, 2, 'h000000, 0, "R4");   // erase of small block 0
        step(1, 3, 'h000000, 0, "R6");
        step(1, 1, 'h004000, 0, "R7");   // neighbouring small block
        step(0, 0, 0, 1, "R10");
        step(1, 4, 'h000000, 0, "R6");
        step(0, 0, 0, 1, "R10");
        step(0, 0, 0, 0, "R3");
        summary();
    end
endmodule